// File: doc/BRIEF.md
# Lazy-Stacking Fault Pend Unit

This unit records a fault exception raised while the floating-point register file is being written to the stack lazily. The ordinary escalation rule looks at the live state of the interrupt controller. This unit does not. It decides whether the fault becomes a HardFault from readiness flags that were latched when the stack frame was first built. Those flags arrive as two saved words, one for the secure bank and one for the non-secure bank. The unit then sets the pending bit of the chosen vector in the chosen security bank.

Each request is one cycle wide. It carries an exception number and a bank bit. The unit resolves the request in that same cycle. It registers the new pending bits together with a sticky forced-escalation bit and a sticky lockup flag. When a pending bit goes from clear to set, the unit pulses a strobe so that the arbiter can recompute priorities. It drives no interrupt line. Exception numbers follow the usual fault layout: HardFault 3, MemManage 4, BusFault 5, UsageFault 6, SecureFault 7, DebugMonitor 12. A readiness word is six bits: [0] HardFault-ready, [1] MemManage-ready, [2] BusFault-ready, [3] UsageFault-ready, [4] SecureFault-ready, [5] monitor-ready.

Top module: `lazy_fault_pend`

## Requirements
- R1: A synchronous reset clears every pending bit in both banks. It also clears the forced bit, lockup, the recompute strobe and the error flag.
- R2: DebugMonitor (12) is discarded with no output change when bit 5 of the secure saved word is clear. When that bit is set, it pends non-secure-bank vector 12.
- R3: MemManage (4) escalates to HardFault when bit 1 of the saved word for the request's bank is clear. Otherwise it pends vector 4 in the request's bank.
- R4: UsageFault (6) escalates when bit 3 of the saved word for the request's bank is clear. Otherwise it pends vector 6 in the request's bank.
- R5: BusFault (5) escalates when bit 2 of the secure saved word is clear. SecureFault (7) escalates when bit 4 of the secure saved word is clear. Neither reads the non-secure word. When they do not escalate, both pend in the non-secure bank.
- R6: An escalated fault pends vector 3. It goes in the secure bank when the security extension is present and either the original fault targeted secure state or the HardFault-to-non-secure control is clear. Otherwise it goes in the non-secure bank. A banked fault targets the bank of its request. A non-banked fault targets secure when its bit in the target mask is set.
- R7: Lockup is raised in the cycle after a request when two conditions both hold. First, the chosen vector is disabled, or the execution priority is numerically less than or equal to its priority. Second, bit 0 of the secure saved word is clear. Lockup then stays set until reset. The pending bit is still set.
- R8: Any escalation sets the forced bit, which stays set until reset.
- R9: The recompute strobe is high for exactly the one cycle after a request that changes a pending bit from 0 to 1. A request whose target bit is already set leaves the strobe low.
- R10: Each of the following is illegal:
  - an exception number outside {4,5,6,7,12};
  - the secure bank bit on 5, 7 or 12.

  An illegal request sets a sticky error flag and changes no pending bit, forced bit, lockup or strobe.
- R11: A legal request is visible on the outputs one clock after it is sampled. Cycles without a request leave every output unchanged, except that the strobe returns low.

Priorities are 9-bit unsigned values. A lower value means a higher priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, one per cycle |
| req_exc | input | IDX_W (4) | Requested exception number |
| req_sec | input | 1 | Bank of the request (1 = secure copy of a banked fault) |
| rdy_s | input | 6 | Secure saved readiness word |
| rdy_ns | input | 6 | Non-secure saved readiness word |
| en_s | input | NUM_VEC (16) | Secure-bank vector enables |
| en_ns | input | NUM_VEC (16) | Non-secure-bank vector enables |
| prio_s | input | NUM_VEC*PRIO_W (144) | Secure-bank vector priorities, vector i at [i*PRIO_W +: PRIO_W] |
| prio_ns | input | NUM_VEC*PRIO_W (144) | Non-secure-bank vector priorities, same packing |
| exec_prio | input | PRIO_W (9) | Current execution priority |
| sec_ext | input | 1 | Security extension present |
| hf_to_ns | input | 1 | HardFault routed to non-secure control |
| nb_tgt_s | input | NUM_VEC (16) | Per-vector secure target for non-banked faults |
| pend_s | output | NUM_VEC (16) | Secure-bank pending bits |
| pend_ns | output | NUM_VEC (16) | Non-secure-bank pending bits |
| hf_forced | output | 1 | Sticky forced-escalation status |
| lockup | output | 1 | Sticky lockup indication |
| recompute | output | 1 | One-cycle priority recompute strobe |
| req_err | output | 1 | Sticky illegal-request flag |

## Verification
The hardest cases to reach are the ones where the two saved words disagree. A MemManage or UsageFault request must escalate because its own bank's word says not ready, even though the other word says ready. The stimulus sets exactly one ready bit clear in one word and issues the fault from each bank in turn. The lockup boundary is also hard to reach, because it needs the HardFault-ready bit clear together with a blocked vector. The bench reaches it in three ways: by stepping the execution priority from one above the vector priority to equal to it, by disabling the vector, and by repeating with the ready bit set.

// File: rtl/lzf_pkg.sv
package lzf_pkg;

    localparam int EXC_HARD   = 3;
    localparam int EXC_MEMM   = 4;
    localparam int EXC_BUS    = 5;
    localparam int EXC_USAGE  = 6;
    localparam int EXC_SECF   = 7;
    localparam int EXC_DBGMON = 12;

    localparam int RDY_W = 6;

    // Saved readiness word; hard is bit 0, mon is bit 5.
    typedef struct packed {
        logic mon;
        logic secf;
        logic usage;
        logic bus;
        logic memm;
        logic hard;
    } rdy_t;

endpackage

// File: rtl/lzf_classify.sv
module lzf_classify
    import lzf_pkg::*;
#(
    parameter int NUM_VEC = 16,
    parameter int IDX_W   = $clog2(NUM_VEC)
) (
    input  logic [IDX_W-1:0]   req_exc,
    input  logic               req_sec,
    input  rdy_t               rdy_s,
    input  rdy_t               rdy_ns,
    input  logic               sec_ext,
    input  logic               hf_to_ns,
    input  logic [NUM_VEC-1:0] nb_tgt_s,
    output logic               legal,
    output logic               drop,
    output logic               escalate,
    output logic               tgt_sec,
    output logic [IDX_W-1:0]   tgt_idx
);

    logic bank_memm, bank_usage;
    logic is_banked, orig_sec, in_range;
    logic unused_ns_bits;

    // Only the banked faults consult the non-secure word.
    assign unused_ns_bits = ^{rdy_ns.hard, rdy_ns.bus, rdy_ns.secf, rdy_ns.mon};
    assign bank_memm      = req_sec ? rdy_s.memm  : rdy_ns.memm;
    assign bank_usage     = req_sec ? rdy_s.usage : rdy_ns.usage;
    assign in_range       = int'(req_exc) < NUM_VEC;

    always_comb begin
        legal     = 1'b0;
        drop      = 1'b0;
        escalate  = 1'b0;
        is_banked = 1'b0;
        case (req_exc)
            IDX_W'(EXC_MEMM): begin
                legal     = 1'b1;
                is_banked = 1'b1;
                escalate  = !bank_memm;
            end
            IDX_W'(EXC_USAGE): begin
                legal     = 1'b1;
                is_banked = 1'b1;
                escalate  = !bank_usage;
            end
            IDX_W'(EXC_BUS): begin
                legal    = !req_sec;
                escalate = !rdy_s.bus;
            end
            IDX_W'(EXC_SECF): begin
                legal    = !req_sec;
                escalate = !rdy_s.secf;
            end
            IDX_W'(EXC_DBGMON): begin
                legal = !req_sec;
                drop  = !rdy_s.mon;
            end
            default: legal = 1'b0;
        endcase
        legal = legal && in_range;

        orig_sec = is_banked ? req_sec : (in_range && nb_tgt_s[req_exc]);

        if (escalate) begin
            tgt_idx = IDX_W'(EXC_HARD);
            tgt_sec = sec_ext && (orig_sec || !hf_to_ns);
        end else begin
            tgt_idx = req_exc;
            tgt_sec = is_banked && req_sec;
        end
    end

endmodule

// File: rtl/lzf_preempt_chk.sv
module lzf_preempt_chk #(
    parameter int NUM_VEC = 16,
    parameter int PRIO_W  = 9,
    parameter int IDX_W   = $clog2(NUM_VEC)
) (
    input  logic                      tgt_sec,
    input  logic [IDX_W-1:0]          tgt_idx,
    input  logic [NUM_VEC-1:0]        en_s,
    input  logic [NUM_VEC-1:0]        en_ns,
    input  logic [NUM_VEC*PRIO_W-1:0] prio_s,
    input  logic [NUM_VEC*PRIO_W-1:0] prio_ns,
    input  logic [PRIO_W-1:0]         exec_prio,
    output logic                      blocked
);

    logic [PRIO_W-1:0] pri_s_arr  [NUM_VEC];
    logic [PRIO_W-1:0] pri_ns_arr [NUM_VEC];

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_unpack
        assign pri_s_arr[v]  = prio_s[v*PRIO_W +: PRIO_W];
        assign pri_ns_arr[v] = prio_ns[v*PRIO_W +: PRIO_W];
    end

    logic              sel_en;
    logic [PRIO_W-1:0] sel_pri;

    always_comb begin
        sel_en  = tgt_sec ? en_s[tgt_idx] : en_ns[tgt_idx];
        sel_pri = tgt_sec ? pri_s_arr[tgt_idx] : pri_ns_arr[tgt_idx];
        // Lower value is higher priority; equal cannot pre-empt.
        blocked = !sel_en || (exec_prio <= sel_pri);
    end

endmodule

// File: rtl/lazy_fault_pend.sv
module lazy_fault_pend
    import lzf_pkg::*;
#(
    parameter int NUM_VEC = 16,
    parameter int PRIO_W  = 9,
    parameter int IDX_W   = $clog2(NUM_VEC)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [IDX_W-1:0]          req_exc,
    input  logic                      req_sec,
    input  logic [RDY_W-1:0]          rdy_s,
    input  logic [RDY_W-1:0]          rdy_ns,
    input  logic [NUM_VEC-1:0]        en_s,
    input  logic [NUM_VEC-1:0]        en_ns,
    input  logic [NUM_VEC*PRIO_W-1:0] prio_s,
    input  logic [NUM_VEC*PRIO_W-1:0] prio_ns,
    input  logic [PRIO_W-1:0]         exec_prio,
    input  logic                      sec_ext,
    input  logic                      hf_to_ns,
    input  logic [NUM_VEC-1:0]        nb_tgt_s,
    output logic [NUM_VEC-1:0]        pend_s,
    output logic [NUM_VEC-1:0]        pend_ns,
    output logic                      hf_forced,
    output logic                      lockup,
    output logic                      recompute,
    output logic                      req_err
);

    typedef struct packed {
        logic [NUM_VEC-1:0] pend_s;
        logic [NUM_VEC-1:0] pend_ns;
        logic               forced;
        logic               lock;
        logic               recomp;
        logic               err;
    } state_t;

    state_t state_d, state_q;

    rdy_t             rs, rn;
    logic             legal, drop, escalate, tgt_sec, blocked;
    logic [IDX_W-1:0] tgt_idx;

    assign rs = rdy_t'(rdy_s);
    assign rn = rdy_t'(rdy_ns);

    lzf_classify #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_classify (
        .req_exc  (req_exc),
        .req_sec  (req_sec),
        .rdy_s    (rs),
        .rdy_ns   (rn),
        .sec_ext  (sec_ext),
        .hf_to_ns (hf_to_ns),
        .nb_tgt_s (nb_tgt_s),
        .legal    (legal),
        .drop     (drop),
        .escalate (escalate),
        .tgt_sec  (tgt_sec),
        .tgt_idx  (tgt_idx)
    );

    lzf_preempt_chk #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_preempt (
        .tgt_sec   (tgt_sec),
        .tgt_idx   (tgt_idx),
        .en_s      (en_s),
        .en_ns     (en_ns),
        .prio_s    (prio_s),
        .prio_ns   (prio_ns),
        .exec_prio (exec_prio),
        .blocked   (blocked)
    );

    always_comb begin
        state_d        = state_q;
        state_d.recomp = 1'b0;
        if (req_valid) begin
            if (!legal) begin
                state_d.err = 1'b1;
            end else if (!drop) begin
                if (escalate) state_d.forced = 1'b1;
                if (blocked && !rs.hard) state_d.lock = 1'b1;
                if (tgt_sec) begin
                    if (!state_q.pend_s[tgt_idx]) begin
                        state_d.pend_s[tgt_idx] = 1'b1;
                        state_d.recomp          = 1'b1;
                    end
                end else begin
                    if (!state_q.pend_ns[tgt_idx]) begin
                        state_d.pend_ns[tgt_idx] = 1'b1;
                        state_d.recomp           = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign pend_s    = state_q.pend_s;
    assign pend_ns   = state_q.pend_ns;
    assign hf_forced = state_q.forced;
    assign lockup    = state_q.lock;
    assign recompute = state_q.recomp;
    assign req_err   = state_q.err;

endmodule

// File: rtl/lzf_escalate_chk.sv
module lzf_escalate_chk #(
    parameter int NUM_VEC = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [NUM_VEC-1:0] pend_s,
    input logic [NUM_VEC-1:0] pend_ns,
    input logic               hf_forced,
    input logic               lockup,
    input logic               recompute,
    input logic               req_err
);

    logic [2*NUM_VEC-1:0] all_pend;
    assign all_pend = {pend_s, pend_ns};

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (all_pend == '0) && !hf_forced && !lockup && !recompute && !req_err);

    a_r7_lockup_sticky: assert property (@(posedge clk) disable iff (rst)
        lockup |=> lockup);

    a_r8_forced_sticky: assert property (@(posedge clk) disable iff (rst)
        hf_forced |=> hf_forced);

    a_r9_strobe_one_new_bit: assert property (@(posedge clk) disable iff (rst)
        recompute |-> $countones(all_pend) == $countones($past(all_pend)) + 1);

    a_r9_bits_never_drop: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(all_pend) & ~all_pend) == '0));

    a_r10_error_quiet: assert property (@(posedge clk) disable iff (rst)
        $rose(req_err) |-> $stable(all_pend) && !recompute);

    a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(all_pend) && !recompute);

endmodule

bind lazy_fault_pend lzf_escalate_chk #(.NUM_VEC(NUM_VEC)) u_lzf_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .pend_s    (pend_s),
    .pend_ns   (pend_ns),
    .hf_forced (hf_forced),
    .lockup    (lockup),
    .recompute (recompute),
    .req_err   (req_err)
);

// File: tb/test_lazy_fault_pend.sv
module test_lazy_fault_pend;

    localparam int NV = 16;
    localparam int PW = 9;

    // 100 MHz: 10 ns period, 1 ns units assumed.
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [3:0]       req_exc = '0;
    logic             req_sec = 1'b0;
    logic [5:0]       rdy_s = 6'h3F, rdy_ns = 6'h3F;
    logic [NV-1:0]    en_s = '1, en_ns = '1;
    logic [NV*PW-1:0] prio_s, prio_ns;
    logic [PW-1:0]    exec_prio = 9'h100;
    logic             sec_ext = 1'b1, hf_to_ns = 1'b0;
    logic [NV-1:0]    nb_tgt_s = 16'h0080;
    logic [NV-1:0]    pend_s, pend_ns;
    logic             hf_forced, lockup, recompute, req_err;

    lazy_fault_pend #(.NUM_VEC(NV), .PRIO_W(PW)) i_lazy_fault_pend (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_exc(req_exc),
        .req_sec(req_sec), .rdy_s(rdy_s), .rdy_ns(rdy_ns), .en_s(en_s),
        .en_ns(en_ns), .prio_s(prio_s), .prio_ns(prio_ns),
        .exec_prio(exec_prio), .sec_ext(sec_ext), .hf_to_ns(hf_to_ns),
        .nb_tgt_s(nb_tgt_s), .pend_s(pend_s), .pend_ns(pend_ns),
        .hf_forced(hf_forced), .lockup(lockup), .recompute(recompute),
        .req_err(req_err)
    );

    typedef struct {
        logic [NV-1:0] ps, pn;
        logic          f, l, rc, e;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_run = 0, n_fail = 0;
    bit   done = 1'b0;

    logic [NV-1:0] m_ps, m_pn;
    logic          m_f, m_l, m_e;

    function automatic void set_all_prio(input logic [PW-1:0] p);
        for (int i = 0; i < NV; i++) begin
            prio_s[i*PW +: PW]  = p;
            prio_ns[i*PW +: PW] = p;
        end
    endfunction

    // Reference model built from R2..R10.
    task automatic push_expected(input logic v, input int exc, input logic sec, input string tag);
        exp_t x;
        logic ok, drop, esc, banked, osec, bsec, en;
        int idx;
        logic [PW-1:0] pr;
        x.rc = 1'b0;
        if (rst) begin
            m_ps = '0; m_pn = '0; m_f = 0; m_l = 0; m_e = 0;
        end else if (v) begin
            ok = 0; drop = 0; esc = 0;
            case (exc)
                4:  begin ok = 1; esc = !(sec ? rdy_s[1] : rdy_ns[1]); end
                6:  begin ok = 1; esc = !(sec ? rdy_s[3] : rdy_ns[3]); end
                5:  begin ok = !sec; esc = !rdy_s[2]; end
                7:  begin ok = !sec; esc = !rdy_s[4]; end
                12: begin ok = !sec; drop = !rdy_s[5]; end
                default: ok = 0;
            endcase
            if (!ok) m_e = 1;
            else if (!drop) begin
                banked = (exc == 4) || (exc == 6);
                osec   = banked ? sec : nb_tgt_s[exc];
                if (esc) begin
                    idx = 3; bsec = sec_ext && (osec || !hf_to_ns); m_f = 1;
                end else begin
                    idx = exc; bsec = banked && sec;
                end
                en = bsec ? en_s[idx] : en_ns[idx];
                pr = bsec ? prio_s[idx*PW +: PW] : prio_ns[idx*PW +: PW];
                if ((!en || exec_prio <= pr) && !rdy_s[0]) m_l = 1;
                if (bsec && !m_ps[idx])       begin m_ps[idx] = 1; x.rc = 1; end
                else if (!bsec && !m_pn[idx]) begin m_pn[idx] = 1; x.rc = 1; end
            end
        end
        x.ps = m_ps; x.pn = m_pn; x.f = m_f; x.l = m_l; x.e = m_e; x.tag = tag;
        exp_q.push_back(x);
    endtask

    task automatic step(input logic v, input int exc, input logic sec, input string tag);
        @(negedge clk);
        rst = 0; req_valid = v; req_exc = 4'(exc); req_sec = sec;
        push_expected(v, exc, sec, tag);
        @(posedge clk); #1;
    endtask

    task automatic do_reset(input string tag);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            rst = 1; req_valid = 0;
            push_expected(0, 0, 0, tag);
            @(posedge clk); #1;
        end
    endtask

    // Monitor: compare each completed cycle against its queued expectation.
    always begin
        @(posedge clk); #2;
        if (exp_q.size() > 0) begin
            exp_t x;
            x = exp_q.pop_front();
            n_run++;
            if (pend_s !== x.ps || pend_ns !== x.pn || hf_forced !== x.f ||
                lockup !== x.l || recompute !== x.rc || req_err !== x.e) begin
                n_fail++;
                $display("FAIL %s: got ps=%h pn=%h f=%b l=%b rc=%b e=%b exp ps=%h pn=%h f=%b l=%b rc=%b e=%b",
                         x.tag, pend_s, pend_ns, hf_forced, lockup, recompute, req_err,
                         x.ps, x.pn, x.f, x.l, x.rc, x.e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        set_all_prio(9'h080);
        do_reset("R1 reset state");
        step(0, 0, 0, "R1 idle after reset");
        step(1, 4, 0, "R3 memmanage ns pends ns[4]");
        step(0, 0, 0, "R11 idle holds");
        step(1, 4, 0, "R9 repeat gives no strobe");
        step(1, 4, 1, "R3 memmanage s pends s[4]");
        rdy_s[1] = 0;
        step(1, 4, 1, "R3 R6 R8 s-bank not ready escalates to s[3]");
        rdy_s = 6'h3F; rdy_ns[3] = 0; hf_to_ns = 1;
        step(1, 6, 0, "R4 R6 usage ns escalates to ns[3]");
        rdy_ns = 6'h3F;
        step(1, 6, 1, "R4 usage s pends s[6]");
        rdy_s[5] = 0;
        step(1, 12, 0, "R2 monitor dropped");
        rdy_s = 6'h3F;
        step(1, 12, 0, "R2 monitor pends ns[12]");
        step(1, 5, 0, "R5 bus pends ns[5]");
        step(1, 3, 0, "R10 hardfault request illegal");
        step(1, 5, 1, "R10 bus with secure bank illegal");

        do_reset("R1 reset clears");
        rdy_s[4] = 0;
        step(1, 7, 0, "R5 R6 secure fault escalates to s[3]");
        rdy_s = 6'h3F; rdy_s[2] = 0; rdy_ns[2] = 1;
        step(1, 5, 0, "R5 R6 bus escalates to ns[3]");

        do_reset("R1 reset");
        sec_ext = 0; hf_to_ns = 0; rdy_s = 6'h3F; rdy_s[1] = 0;
        step(1, 4, 1, "R6 no security extension goes to ns[3]");

        do_reset("R1 reset");
        sec_ext = 1; rdy_s = 6'h3E; exec_prio = 9'h081;
        step(1, 4, 0, "R7 exec above prio no lockup");
        exec_prio = 9'h080;
        step(1, 5, 0, "R7 equal priority lockup");
        step(0, 0, 0, "R7 lockup sticky");

        do_reset("R1 reset");
        exec_prio = 9'h100; en_ns[12] = 0;
        step(1, 12, 0, "R7 disabled vector lockup");

        do_reset("R1 reset");
        rdy_s = 6'h3F; en_ns = '1; exec_prio = 9'h010;
        step(1, 6, 0, "R7 hardfault ready no lockup");
        step(0, 0, 0, "R11 final idle");

        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule